// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

This block is a very small 8-bit processor built around one accumulator and a 16-bit program counter. It fetches opcodes and operand bytes from a single synchronous memory and executes a fixed set of seven instructions: no-op, clear, increment, add-immediate, direct load, direct store and unconditional jump. Every machine cycle is exactly one memory access. An access holds its address and strobe for a fixed number of clocks. Two-byte addresses are collected low byte first into a pair of temporary registers, and that pair later drives the bus or the program counter.

The core can run freely or one instruction at a time. When stepping is enabled, the core parks at each opcode fetch with both strobes low. A one-clock step pulse releases it, and it then finishes the whole instruction before parking again. The accumulator, program counter and the two flags are brought out so that a monitor or a testbench can follow execution.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted both memory strobes are low. After reset the program counter is 8200 hex, and the accumulator, zero flag and carry flag are all zero.
- R2: Each machine cycle performs one memory access. The access keeps its address and strobe constant for CYC_CLKS clocks, and read data is taken on the last clock of the cycle.
- R3: Opcode encodings are 00 no-op, AF clear, 3C increment, C6 add-immediate, 3A load, 32 store and C3 jump. No-op, clear and increment take one machine cycle. Add-immediate takes two, jump takes three, and load and store take four each. The program counter advances by the instruction length: 1, 2 or 3 bytes.
- R4: Clear sets the accumulator to zero and sets the zero flag. The carry flag is left unchanged.
- R5: Increment adds one modulo 256 and updates the zero flag. The carry flag is left unchanged.
- R6: Add-immediate adds the second instruction byte modulo 256. The carry flag becomes bit 8 of the sum, and the zero flag is updated.
- R7: Load reads byte two (the low address) and then byte three (the high address). It then reads the address high:low into the accumulator and leaves both flags unchanged.
- R8: Store collects its address the same way and writes the accumulator to high:low. The write strobe is raised only during that data cycle.
- R9: Jump loads the program counter with high:low, taken from bytes three and two.
- R10: Any other opcode executes as a one-byte, one-cycle no-op and leaves the accumulator and flags unchanged.
- R11: With stepping enabled, the core stays at an opcode fetch with both strobes low until a step pulse arrives. It then runs exactly one complete instruction. A step pulse that arrives while an instruction is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Single-step mode enable |
| step | input | 1 | One-clock pulse that releases one instruction |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_rdata | input | 8 | Read data, valid one clock after the read is issued |
| acc | output | 8 | Accumulator |
| pc | output | ADDR_W | Program counter |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Increment is run once from every one of the 256 starting values. This tells a correct modulo-256 wrap apart from a lost or mis-set zero flag, and confirms that carry is held. Add-immediate is swept over a grid of accumulator and operand values that includes sums that stay in range, sums that overflow and sums that land exactly on zero, which separates the carry and zero updates. Every undefined opcode is executed, and so are stores and jumps to spread addresses, each with the read and write strobe counts compared against the cycle count. A free-running copy of a load, increment, store and jump loop, together with a step pulse injected in the middle of an instruction, separates continuous execution from stepped execution.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OPC_NOP   = 8'h00;
   localparam logic [BYTE_W-1:0] OPC_CLR   = 8'hAF;
   localparam logic [BYTE_W-1:0] OPC_INC   = 8'h3C;
   localparam logic [BYTE_W-1:0] OPC_ADDI  = 8'hC6;
   localparam logic [BYTE_W-1:0] OPC_LOAD  = 8'h3A;
   localparam logic [BYTE_W-1:0] OPC_STORE = 8'h32;
   localparam logic [BYTE_W-1:0] OPC_JUMP  = 8'hC3;

   typedef enum logic [2:0] {
      K_NOP, K_CLR, K_INC, K_ADD, K_LOAD, K_STORE, K_JUMP
   } kind_t;

   // machine cycle being run: opcode fetch, byte two, byte three, data access
   typedef enum logic [1:0] {
      PH_OP, PH_LO, PH_HI, PH_DATA
   } phase_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_core_pkg::*;
(
   input  logic [BYTE_W-1:0] opcode,
   output kind_t             kind
);

   always_comb begin
      case (opcode)
         OPC_CLR:   kind = K_CLR;
         OPC_INC:   kind = K_INC;
         OPC_ADDI:  kind = K_ADD;
         OPC_LOAD:  kind = K_LOAD;
         OPC_STORE: kind = K_STORE;
         OPC_JUMP:  kind = K_JUMP;
         default:   kind = K_NOP;   // R10: anything else runs as a no-op
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
(
   input  kind_t             kind,
   input  logic [BYTE_W-1:0] a_in,
   input  logic [BYTE_W-1:0] operand,
   output logic [BYTE_W-1:0] result,
   output logic              carry,
   output logic              zero
);

   logic [BYTE_W:0] sum;

   always_comb begin
      case (kind)
         K_INC:   sum = {1'b0, a_in} + (BYTE_W+1)'(1);
         K_ADD:   sum = {1'b0, a_in} + {1'b0, operand};
         K_CLR:   sum = {1'b0, a_in ^ a_in};
         default: sum = {1'b0, a_in};
      endcase
      result = sum[BYTE_W-1:0];
      carry  = sum[BYTE_W];
      zero   = (sum[BYTE_W-1:0] == '0);
   end

endmodule

// File: rtl/acc_cycle_timer.sv
module acc_cycle_timer #(
   parameter int CYC_CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic first_o,
   output logic last_o
);

   localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
   localparam bit POW2  = ((CYC_CLKS & (CYC_CLKS - 1)) == 0);

   if (CYC_CLKS < 2) begin : g_bad_len
      $error("acc_cycle_timer: CYC_CLKS must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign first_o = (cnt_q == '0);
   assign last_o  = (cnt_q == CNT_W'(CYC_CLKS - 1));

   if (POW2) begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)     cnt_q <= '0;
         else if (!hold) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n)      cnt_q <= '0;
         else if (!hold)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: a finished machine cycle always restarts at its first clock
   p_cycle_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> first_o);

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int                 ADDR_W   = 16,
   parameter int                 CYC_CLKS = 2,
   parameter logic [ADDR_W-1:0]  RESET_PC = 16'h8200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              step,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic [7:0]        acc,
   output logic [ADDR_W-1:0] pc,
   output logic              flag_z,
   output logic              flag_c
);

   localparam int HALF_W = ADDR_W / 2;

   if (ADDR_W != 2 * BYTE_W) begin : g_bad_addr
      $error("acc_core: ADDR_W must be two bytes wide");
   end

   phase_t              phase_q;
   kind_t               ir_q;
   kind_t               dec_kind;
   kind_t               alu_kind;
   logic [BYTE_W-1:0]   acc_q, w_q, z_q;
   logic [ADDR_W-1:0]   pc_q;
   logic                fz_q, fc_q;
   logic                cyc_first, cyc_last, stall;
   logic [BYTE_W-1:0]   alu_res;
   logic                alu_c, alu_z;
   logic                is_write;

   acc_decode u_dec (
      .opcode (mem_rdata),
      .kind   (dec_kind)
   );

   assign alu_kind = (phase_q == PH_OP) ? dec_kind : ir_q;

   acc_alu u_alu (
      .kind    (alu_kind),
      .a_in    (acc_q),
      .operand (mem_rdata),
      .result  (alu_res),
      .carry   (alu_c),
      .zero    (alu_z)
   );

   // R11: park at the first clock of an opcode fetch until released
   assign stall = step_en && !step && (phase_q == PH_OP) && cyc_first;

   acc_cycle_timer #(.CYC_CLKS(CYC_CLKS)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (stall),
      .first_o (cyc_first),
      .last_o  (cyc_last)
   );

   assign is_write  = (phase_q == PH_DATA) && (ir_q == K_STORE);
   assign mem_addr  = (phase_q == PH_DATA) ? {w_q, z_q} : pc_q;
   assign mem_rd    = rst_n && !stall && !is_write;
   assign mem_wr    = rst_n && is_write;
   assign mem_wdata = acc_q;
   assign acc       = acc_q;
   assign pc        = pc_q;
   assign flag_z    = fz_q;
   assign flag_c    = fc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_OP;
         ir_q    <= K_NOP;
         acc_q   <= '0;
         w_q     <= '0;
         z_q     <= '0;
         pc_q    <= RESET_PC;
         fz_q    <= 1'b0;
         fc_q    <= 1'b0;
      end else if (cyc_last) begin
         case (phase_q)
            PH_OP: begin
               pc_q <= pc_q + ADDR_W'(1);
               ir_q <= dec_kind;
               case (dec_kind)
                  K_CLR, K_INC: begin
                     acc_q <= alu_res;
                     fz_q  <= alu_z;
                  end
                  K_ADD, K_LOAD, K_STORE, K_JUMP: phase_q <= PH_LO;
                  default: ;
               endcase
            end
            PH_LO: begin
               pc_q <= pc_q + ADDR_W'(1);
               z_q  <= mem_rdata;
               if (ir_q == K_ADD) begin
                  acc_q   <= alu_res;
                  fz_q    <= alu_z;
                  fc_q    <= alu_c;
                  phase_q <= PH_OP;
               end else begin
                  phase_q <= PH_HI;
               end
            end
            PH_HI: begin
               w_q <= mem_rdata;
               if (ir_q == K_JUMP) begin
                  pc_q    <= {mem_rdata, z_q};
                  phase_q <= PH_OP;
               end else begin
                  pc_q    <= pc_q + ADDR_W'(1);
                  phase_q <= PH_DATA;
               end
            end
            default: begin
               if (ir_q == K_LOAD) acc_q <= mem_rdata;
               phase_q <= PH_OP;
            end
         endcase
      end
   end

   // R3: every completed opcode fetch moves the program counter by one
   p_fetch_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OP && cyc_last) |=> pc_q == $past(pc_q) + ADDR_W'(1));

   // R2: address and strobes are held for the whole machine cycle
   p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_first |-> ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr)));

   // R9: a jump lands on the two collected address bytes
   p_jump_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HI && cyc_last && ir_q == K_JUMP)
      |=> pc_q == {$past(mem_rdata), z_q[HALF_W-1:0]});

   // R5: increment wraps and leaves carry alone
   p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OP && cyc_last && dec_kind == K_INC)
      |=> (acc_q == $past(acc_q) + 8'd1) && $stable(fc_q));

   // R11: a parked core does not move
   p_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(pc_q) && phase_q == PH_OP));

endmodule

// File: tb/test_acc_core.sv
module test_acc_core;

   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b1;
   logic        step = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic [7:0]  acc;
   logic [15:0] pc;
   logic        flag_z, flag_c;

   acc_core #(.ADDR_W(16), .CYC_CLKS(CYC), .RESET_PC(16'h8200)) i_acc_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .step      (step),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .acc       (acc),
      .pc        (pc),
      .flag_z    (flag_z),
      .flag_c    (flag_c)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model: 1 KiB window, synchronous read, bench pokes through the same port
   logic [7:0]  mem [0:1023];
   logic        pk_en = 1'b0;
   logic [15:0] pk_a = '0;
   logic [7:0]  pk_d = '0;
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   logic        wr_q = 1'b0;
   logic        log_on = 1'b0;
   int          wcount = 0;
   logic [15:0] wlog_a [0:63];
   logic [7:0]  wlog_d [0:63];

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
      if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
      else if (pk_en) mem[pk_a[9:0]] <= pk_d;
      if (mem_rd) rd_cnt <= rd_cnt + 1;
      if (mem_wr) wr_cnt <= wr_cnt + 1;
      wr_q <= mem_wr;
      if (log_on && mem_wr && !wr_q && wcount < 64) begin
         wlog_a[wcount] <= mem_addr;
         wlog_d[wcount] <= mem_wdata;
         wcount <= wcount + 1;
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] exp_pc = 16'h8200;
   logic [7:0]  exp_a = 8'h00;
   logic        exp_z = 1'b0;
   logic        exp_c = 1'b0;

   task automatic chk(input string req, input string what, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      finish_run();
   end

   task automatic poke(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      pk_en = 1'b1; pk_a = a; pk_d = d;
      @(posedge clk);
      @(negedge clk);
      pk_en = 1'b0;
   endtask

   // run one instruction in step mode and compare against the model
   task automatic run_op(input logic [7:0] op, input logic [7:0] b2, input logic [7:0] b3);
      int          n, nb, r0, w0;
      logic        st;
      logic [15:0] tgt;
      logic [8:0]  s;
      string       tag;
      tgt = {b3, b2};
      poke(exp_pc, op);
      poke(exp_pc + 16'd1, b2);
      poke(exp_pc + 16'd2, b3);
      n = 1; nb = 1; st = 1'b0; tag = "R10";
      case (op)
         8'h00: tag = "R3";
         8'hAF: begin exp_a = 8'h00; exp_z = 1'b1; tag = "R4"; end
         8'h3C: begin exp_a = exp_a + 8'd1; exp_z = (exp_a == 8'h00); tag = "R5"; end
         8'hC6: begin
            s = {1'b0, exp_a} + {1'b0, b2};
            exp_a = s[7:0]; exp_c = s[8]; exp_z = (s[7:0] == 8'h00);
            n = 2; nb = 2; tag = "R6";
         end
         8'h3A: begin exp_a = mem[tgt[9:0]]; n = 4; nb = 3; tag = "R7"; end
         8'h32: begin n = 4; nb = 3; st = 1'b1; tag = "R8"; end
         8'hC3: begin n = 3; nb = 3; tag = "R9"; end
         default: ;
      endcase
      r0 = rd_cnt; w0 = wr_cnt;
      @(negedge clk) step = 1'b1;
      @(posedge clk);
      @(negedge clk) step = 1'b0;
      repeat (n * CYC - 1) @(posedge clk);
      @(negedge clk);
      if (op == 8'hC3) exp_pc = tgt;
      else exp_pc = exp_pc + 16'(nb);
      chk(tag, "pc", int'(pc), int'(exp_pc));
      chk(tag, "acc", int'(acc), int'(exp_a));
      chk(tag, "flag_z", int'(flag_z), int'(exp_z));
      chk(tag, "flag_c", int'(flag_c), int'(exp_c));
      chk("R2", "read clocks", rd_cnt - r0, (n - int'(st)) * CYC);
      chk("R8", "write clocks", wr_cnt - w0, int'(st) * CYC);
      if (st) chk("R8", "stored byte", int'(mem[tgt[9:0]]), int'(exp_a));
   endtask

   task automatic go(input logic [7:0] op, input logic [7:0] b2, input logic [7:0] b3);
      if (exp_pc > 16'h82F0) run_op(8'hC3, 8'h00, 8'h82);
      run_op(op, b2, b3);
   endtask

   task automatic load_val(input logic [7:0] slot, input logic [7:0] v);
      poke({8'h83, slot}, v);
      go(8'h3A, slot, 8'h83);
   endtask

   initial begin
      int r0;
      logic [7:0] ev;
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "rd in reset", int'(mem_rd), 0);
      chk("R1", "wr in reset", int'(mem_wr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pc", int'(pc), 16'h8200);
      chk("R1", "acc", int'(acc), 0);
      chk("R1", "flag_z", int'(flag_z), 0);
      chk("R1", "flag_c", int'(flag_c), 0);
      chk("R11", "parked rd", int'(mem_rd), 0);

      // R10: every undefined opcode is a one-cycle no-op
      load_val(8'h00, 8'h5A);
      go(8'hC6, 8'hC0, 8'h00);
      for (int op = 0; op < 256; op++) begin
         if (op != 8'hAF && op != 8'h3C && op != 8'hC6 &&
             op != 8'h3A && op != 8'h32 && op != 8'hC3)
            go(8'(op), 8'hC6, 8'h3A);
      end

      // R5: increment from every value
      for (int v = 0; v < 256; v++) begin
         load_val(8'(v), 8'(v));
         go(8'h3C, 8'hAF, 8'hAF);
      end

      // R6: add grid
      for (int a = 0; a < 256; a += 15) begin
         for (int b = 0; b < 256; b += 7) begin
            load_val(8'(a), 8'(a));
            go(8'hC6, 8'(b), 8'h00);
         end
      end
      load_val(8'h10, 8'h80);
      go(8'hC6, 8'h80, 8'h00);

      // R4: clear with carry set
      load_val(8'h11, 8'hF0);
      go(8'hC6, 8'h20, 8'h00);
      go(8'hAF, 8'h00, 8'h00);

      // R8: stores to spread addresses
      for (int k = 0; k < 16; k++) begin
         go(8'hC6, 8'(k * 11 + 1), 8'h00);
         go(8'h32, 8'(k * 13 + 3), 8'h83);
      end

      // R9: jumps to spread targets
      for (int k = 0; k < 16; k++) go(8'hC3, 8'(16 + k * 9), 8'h82);

      // R11: a step pulse mid-instruction is ignored
      poke({8'h83, 8'hEE}, 8'h77);
      poke(exp_pc, 8'h3A);
      poke(exp_pc + 16'd1, 8'hEE);
      poke(exp_pc + 16'd2, 8'h83);
      @(negedge clk) step = 1'b1;
      @(posedge clk);
      @(negedge clk) step = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk) step = 1'b1;
      @(posedge clk);
      @(negedge clk) step = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      exp_pc = exp_pc + 16'd3;
      chk("R11", "pc after stepped load", int'(pc), int'(exp_pc));
      chk("R7", "acc after stepped load", int'(acc), 8'h77);
      r0 = rd_cnt;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R11", "pc while parked", int'(pc), int'(exp_pc));
      chk("R11", "reads while parked", rd_cnt - r0, 0);

      // R2/R7/R8/R9: free-running load-increment-store-jump loop
      rst_n = 1'b0;
      step_en = 1'b0;
      poke(16'h8200, 8'h00); poke(16'h8201, 8'h00); poke(16'h8202, 8'h00);
      poke(16'h8203, 8'hAF);
      poke(16'h8204, 8'h3A); poke(16'h8205, 8'h00); poke(16'h8206, 8'h83);
      poke(16'h8207, 8'h3C);
      poke(16'h8208, 8'h32); poke(16'h8209, 8'h00); poke(16'h820A, 8'h83);
      poke(16'h820B, 8'hC3); poke(16'h820C, 8'h03); poke(16'h820D, 8'h82);
      poke(16'h8300, 8'hFD);
      @(negedge clk);
      log_on = 1'b1;
      rst_n = 1'b1;
      repeat ((3 + 20 * 13) * CYC + 4) @(posedge clk);
      @(negedge clk);
      chk("R8", "loop stores seen", int'(wcount >= 20), 1);
      for (int i = 0; i < 20; i++) begin
         ev = 8'hFE + 8'(i);
         chk("R8", "loop store addr", int'(wlog_a[i]), 16'h8300);
         chk("R5", "loop store value", int'(wlog_d[i]), int'(ev));
      end
      finish_run();
   end

endmodule